// File: doc/BRIEF.md
# Self-Test Sequence Control Register

This block is one 32-bit memory-mapped register. Software uses it to launch three on-chip maintenance sequences: a RAM self-test, an EEPROM self-test and a load of configuration from EEPROM. Software writes a 1 to a sequence's enable bit. The block sends a one-cycle start strobe to the matching engine. It then reports progress through the same register, which software polls.

Each engine answers with a done pulse. The RAM test also returns one fail flag per memory, and the EEPROM test returns a single fail flag. When the engine finishes, the enable bit drops back to 0. The RAM test additionally sets a done bit. Only one sequence runs at a time. An enable written while another sequence is busy is queued and starts once the bus is free. The RAM test must be re-armed through its reset bit before each run.

Top module: `selftest_ctl`

## Requirements
- R1: While and after reset, every bit of `rd_data` reads 0 and no start strobe is asserted.
- R2: Writing 1 to bit 1 starts the EEPROM test. Bit 1 reads 1 until `eet_done` is sampled for the running test and reads 0 from then on. Bit 0 then holds the value of `eet_fail` sampled with that done.
- R3: Writing 1 to bit 2 starts the EEPROM load. Bit 2 reads 1 until `eld_done` is sampled for the running load. The load has no done or fail bit.
- R4: Writing 1 to bit 13 while the RAM test is not running clears bit 9 and the RAM fail field, and arms exactly one RAM start. Bit 13 always reads 0. A write with both bit 13 and bit 10 set is armed and accepted in that same write.
- R5: Writing 1 to bit 10 when the RAM test is not armed is ignored: bit 10 keeps reading 0 and no `ram_start` pulse appears.
- R6: When `ram_done` is sampled for a running RAM test, bit 10 reads 0 and bit 9 reads 1. `ram_fail[0..4]` are captured into bits 3, 4, 5, 7 and 8, in that order.
- R7: Writing an enable bit for a sequence that is already pending or running has no effect: no second start strobe is produced.
- R8: At most one sequence runs at a time. An enable written for another sequence reads back 1 at once, and its strobe waits until the running sequence has finished. When several sequences are pending, they are launched in this order: RAM test first, then EEPROM test, then EEPROM load.
- R9: The fail and done flags hold their values until the RAM reset bit is written (for bits 9, 3, 4, 5, 7 and 8) or a new enable for the same sequence is accepted (for bits 0 and 9/fail field respectively).
- R10: Suppose a write is sampled at clock edge k and the block is idle. The enable bit reads 1 after edge k, and the start strobe is high for exactly the one cycle after edge k+1. Suppose a done is sampled at edge d. The status shows it after edge d, and any queued sequence launches at edge d+1.
- R11: A done pulse from an engine that is not running is ignored, and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Register read value |
| ram_start | output | 1 | One-cycle start to the RAM test engine |
| ram_done | input | 1 | RAM test finished |
| ram_fail | input | 5 | Per-memory RAM test failure, valid with ram_done |
| eet_start | output | 1 | One-cycle start to the EEPROM test engine |
| eet_done | input | 1 | EEPROM test finished |
| eet_fail | input | 1 | EEPROM test failed, valid with eet_done |
| eld_start | output | 1 | One-cycle start to the EEPROM load engine |
| eld_done | input | 1 | EEPROM load finished |

## Verification
An accepted write shows in the read value one edge after it is sampled. The start strobe follows one edge later when the block is idle, or one edge after the done that frees it. The scoreboard therefore stores, for every expected strobe, either an absolute cycle or a marker meaning "one cycle after the latest done". It compares both the engine and the cycle whenever a strobe appears. Status is read back on the falling edge after the done edge, and the bench checks that this cycle equals the cycle in which the engine model raised done. Ignored writes are checked by reading the register back and by flagging any strobe that no queued item expects.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    localparam int NSEQ     = 3;
    localparam int RAM_MEMS = 5;

    // register bit positions that software decodes
    localparam int B_EET_FAIL = 0;
    localparam int B_EET_EN   = 1;
    localparam int B_ELD_EN   = 2;
    localparam int B_RAM_DONE = 9;
    localparam int B_RAM_EN   = 10;
    localparam int B_RAM_RST  = 13;

    // index order is also launch priority (lowest first)
    typedef enum logic [1:0] {
        SEQ_RAM = 2'd0,
        SEQ_EET = 2'd1,
        SEQ_ELD = 2'd2
    } seq_e;

    typedef logic [NSEQ-1:0] seq_vec_t;

    typedef struct packed {
        logic busy;
        seq_e id;
    } run_t;

    // bit position of the fail flag for memory m
    function automatic int ram_fail_pos(input int m);
        case (m)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            3:       return 7;
            default: return 8;
        endcase
    endfunction

    function automatic seq_vec_t seq_bit(input seq_e s);
        seq_vec_t v;
        v = '0;
        v[int'(s)] = 1'b1;
        return v;
    endfunction

    function automatic seq_e pick_first(input seq_vec_t v);
        if (v[int'(SEQ_RAM)])      return SEQ_RAM;
        else if (v[int'(SEQ_EET)]) return SEQ_EET;
        else                       return SEQ_ELD;
    endfunction

endpackage

// File: rtl/st_request.sv
module st_request
    import selftest_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic     wr_ram_en,
    input  logic     wr_eet_en,
    input  logic     wr_eld_en,
    input  logic     wr_ram_rst,
    input  seq_vec_t active,
    input  seq_vec_t running,
    output seq_vec_t req,
    output logic     ram_clear
);

    logic     armed;
    seq_vec_t want;

    always_comb begin
        want                = '0;
        want[int'(SEQ_RAM)] = wr_ram_en;
        want[int'(SEQ_EET)] = wr_eet_en;
        want[int'(SEQ_ELD)] = wr_eld_en;
    end

    assign ram_clear = wr_en && wr_ram_rst && !running[int'(SEQ_RAM)];

    always_comb begin
        req = wr_en ? (want & ~active) : '0;
        if (!(armed || ram_clear))
            req[int'(SEQ_RAM)] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (req[int'(SEQ_RAM)])
            armed <= 1'b0;
        else if (ram_clear)
            armed <= 1'b1;
    end

    // an accepted RAM start always uses up the arming
    p_arm_consumed_r5: assert property (@(posedge clk) disable iff (rst)
        req[int'(SEQ_RAM)] |=> !armed);

endmodule

// File: rtl/st_arbiter.sv
module st_arbiter
    import selftest_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_vec_t req,
    input  seq_vec_t done_vec,
    output seq_vec_t pend,
    output seq_vec_t running,
    output seq_vec_t start,
    output seq_vec_t finish
);

    run_t     run;
    seq_vec_t pend_q;
    seq_vec_t start_q;
    logic     launch;
    seq_e     nxt;
    seq_vec_t take;

    assign nxt     = pick_first(pend_q);
    assign launch  = !run.busy && (|pend_q);
    assign take    = launch ? seq_bit(nxt) : '0;
    assign running = run.busy ? seq_bit(run.id) : '0;
    assign finish  = done_vec & running;
    assign pend    = pend_q;
    assign start   = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            start_q <= '0;
            run     <= '{busy: 1'b0, id: SEQ_RAM};
        end else begin
            pend_q  <= (pend_q | req) & ~take;
            start_q <= take;
            if (launch)
                run <= '{busy: 1'b1, id: nxt};
            else if (|finish)
                run.busy <= 1'b0;
        end
    end

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_q));

    p_strobe_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (|start_q) |-> (run.busy && !$past(run.busy)));

    p_finish_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (|finish) |=> (((pend_q | running) & $past(finish)) == '0));

endmodule

// File: rtl/st_flags.sv
module st_flags
    import selftest_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  seq_vec_t            finish,
    input  seq_vec_t            req,
    input  logic                ram_clear,
    input  logic [RAM_MEMS-1:0] ram_fail,
    input  logic                eet_fail,
    output logic                ram_done_f,
    output logic [RAM_MEMS-1:0] ram_fail_f,
    output logic                eet_fail_f
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_done_f <= 1'b0;
            ram_fail_f <= '0;
        end else if (ram_clear || req[int'(SEQ_RAM)]) begin
            ram_done_f <= 1'b0;
            ram_fail_f <= '0;
        end else if (finish[int'(SEQ_RAM)]) begin
            ram_done_f <= 1'b1;
            ram_fail_f <= ram_fail;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            eet_fail_f <= 1'b0;
        else if (req[int'(SEQ_EET)])
            eet_fail_f <= 1'b0;
        else if (finish[int'(SEQ_EET)])
            eet_fail_f <= eet_fail;
    end

    p_ram_done_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_done_f) |-> $past(finish[int'(SEQ_RAM)]));

    p_eet_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!finish[int'(SEQ_EET)] && !req[int'(SEQ_EET)]) |=> $stable(eet_fail_f));

endmodule

// File: rtl/selftest_ctl.sv
module selftest_ctl
    import selftest_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic                ram_start,
    input  logic                ram_done,
    input  logic [RAM_MEMS-1:0] ram_fail,
    output logic                eet_start,
    input  logic                eet_done,
    input  logic                eet_fail,
    output logic                eld_start,
    input  logic                eld_done
);

    seq_vec_t            req, pend, running, start, finish, done_vec, active;
    logic                ram_clear;
    logic                ram_done_f, eet_fail_f;
    logic [RAM_MEMS-1:0] ram_fail_f;

    assign active = pend | running;

    always_comb begin
        done_vec                = '0;
        done_vec[int'(SEQ_RAM)] = ram_done;
        done_vec[int'(SEQ_EET)] = eet_done;
        done_vec[int'(SEQ_ELD)] = eld_done;
    end

    st_request u_req (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_ram_en  (wr_data[B_RAM_EN]),
        .wr_eet_en  (wr_data[B_EET_EN]),
        .wr_eld_en  (wr_data[B_ELD_EN]),
        .wr_ram_rst (wr_data[B_RAM_RST]),
        .active     (active),
        .running    (running),
        .req        (req),
        .ram_clear  (ram_clear)
    );

    st_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .done_vec (done_vec),
        .pend     (pend),
        .running  (running),
        .start    (start),
        .finish   (finish)
    );

    st_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .finish     (finish),
        .req        (req),
        .ram_clear  (ram_clear),
        .ram_fail   (ram_fail),
        .eet_fail   (eet_fail),
        .ram_done_f (ram_done_f),
        .ram_fail_f (ram_fail_f),
        .eet_fail_f (eet_fail_f)
    );

    assign ram_start = start[int'(SEQ_RAM)];
    assign eet_start = start[int'(SEQ_EET)];
    assign eld_start = start[int'(SEQ_ELD)];

    always_comb begin
        rd_data             = '0;
        rd_data[B_EET_FAIL] = eet_fail_f;
        rd_data[B_EET_EN]   = active[int'(SEQ_EET)];
        rd_data[B_ELD_EN]   = active[int'(SEQ_ELD)];
        rd_data[B_RAM_EN]   = active[int'(SEQ_RAM)];
        rd_data[B_RAM_DONE] = ram_done_f;
        for (int m = 0; m < RAM_MEMS; m++)
            rd_data[ram_fail_pos(m)] = ram_fail_f[m];
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !ram_start && !eet_start && !eld_start));

endmodule

// File: tb/selftest_ctl_test.sv
module selftest_ctl_test;
    import selftest_pkg::*;

    localparam int LAT_RAM = 6;
    localparam int LAT_EET = 4;
    localparam int LAT_ELD = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ram_start, eet_start, eld_start;
    logic [2:0]  mdone = '0;
    logic        stray_eet = 1'b0;
    logic [4:0]  ram_fail_val = '0;
    logic        eet_fail_val = 1'b0;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int last_done = 0;
    int cnt [3] = '{0, 0, 0};

    typedef struct { int id; int when; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    selftest_ctl uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ram_start (ram_start),
        .ram_done  (mdone[0]),
        .ram_fail  (ram_fail_val),
        .eet_start (eet_start),
        .eet_done  (mdone[1] | stray_eet),
        .eet_fail  (eet_fail_val),
        .eld_start (eld_start),
        .eld_done  (mdone[2])
    );

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    function automatic int lat(input int i);
        return (i == 0) ? LAT_RAM : (i == 1) ? LAT_EET : LAT_ELD;
    endfunction

    // engine models
    always @(negedge clk) begin
        logic [2:0] s;
        s = {eld_start, eet_start, ram_start};
        for (int i = 0; i < 3; i++) begin
            if (mdone[i]) mdone[i] = 1'b0;
            if (s[i]) cnt[i] = lat(i);
            else if (cnt[i] > 0) begin
                cnt[i]--;
                if (cnt[i] == 0) begin
                    mdone[i]  = 1'b1;
                    last_done = cyc + 1;
                end
            end
        end
    end

    // scoreboard monitor for start strobes
    always @(negedge clk) begin
        logic [2:0] s;
        s = {eld_start, eet_start, ram_start};
        if (!rst && s != 3'b000) begin
            if (q.size() == 0) begin
                chk("R5/R7 unexpected strobe", {29'd0, s}, 32'd0);
            end else begin
                exp_t e;
                int   want;
                e = q.pop_front();
                want = (e.when < 0) ? last_done + 1 : e.when;
                chk("R8 strobe engine", {29'd0, s}, 32'd1 << e.id);
                chk("R10 strobe cycle", cyc, want);
            end
        end
    end

    task automatic write_reg(input logic [31:0] d, output int k);
        @(negedge clk);
        k = cyc + 1;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic launch(input logic [31:0] d, input int id);
        int k;
        write_reg(d, k);
        q.push_back('{id: id, when: k + 1});
    endtask

    task automatic wait_clear(input logic [31:0] mask);
        int n;
        n = 0;
        while ((rd_data & mask) != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) chk("R2/R3/R6 completion timeout", rd_data & mask, 32'd0);
        else chk("R10 status after done", cyc, last_done);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset value", rd_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", rd_data, 32'd0);
        chk("R1 no strobe", {29'd0, eld_start, eet_start, ram_start}, 32'd0);

        // EEPROM test, failing
        eet_fail_val = 1'b1;
        launch(32'h2, 1);
        chk("R2 enable reads 1", rd_data, 32'h2);
        wait_clear(32'h2);
        chk("R2 fail captured", rd_data, 32'h1);
        repeat (5) @(negedge clk);
        chk("R9 fail persists", rd_data, 32'h1);
        eet_fail_val = 1'b0;
        launch(32'h2, 1);
        chk("R9 new enable clears fail", rd_data, 32'h2);
        wait_clear(32'h2);
        chk("R2 pass result", rd_data, 32'h0);

        // EEPROM load
        launch(32'h4, 2);
        chk("R3 enable reads 1", rd_data, 32'h4);
        wait_clear(32'h4);
        chk("R3 done, no flags", rd_data, 32'h0);

        // stray done with nothing running
        @(negedge clk);
        eet_fail_val = 1'b1;
        stray_eet = 1'b1;
        @(negedge clk);
        stray_eet = 1'b0;
        @(negedge clk);
        chk("R11 stray done ignored", rd_data, 32'h0);

        // RAM enable without arming
        write_reg(32'h400, k);
        repeat (3) @(negedge clk);
        chk("R5 unarmed ignored", rd_data, 32'h0);

        // arm, run, fail on memories 0,2,4
        write_reg(32'h2000, k);
        chk("R4 reset bit reads 0", rd_data, 32'h0);
        ram_fail_val = 5'b10101;
        launch(32'h400, 0);
        chk("R4 armed start", rd_data, 32'h400);
        write_reg(32'h400, k);
        chk("R7 rewrite while busy", rd_data, 32'h400);
        wait_clear(32'h400);
        chk("R6 done and fail field", rd_data, 32'h328);
        repeat (4) @(negedge clk);
        chk("R9 ram flags persist", rd_data, 32'h328);
        write_reg(32'h400, k);
        repeat (3) @(negedge clk);
        chk("R5 re-run needs reset", rd_data, 32'h328);
        write_reg(32'h2000, k);
        chk("R4 reset clears flags", rd_data, 32'h0);

        // queued and prioritised sequences
        ram_fail_val = 5'b00010;
        eet_fail_val = 1'b1;
        launch(32'h4, 2);
        write_reg(32'h2402, k);
        q.push_back('{id: 0, when: -1});
        q.push_back('{id: 1, when: -1});
        chk("R8 queued enables read 1", rd_data, 32'h406);
        wait_clear(32'h406);
        chk("R8 final status", rd_data, 32'h211);

        repeat (5) @(negedge clk);
        chk("R7 no missing strobes", q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule